// File: doc/BRIEF.md
# Self-Clearing DMA Kick Register Front End

This block sits between a simple register bus and an external data mover, and drives one single-shot DMA channel. Software loads a destination address and a byte count. It then sets the start bit of the control register. The block holds a request toward the mover until the mover answers with a completion strobe and the number of bytes it actually moved.

On completion, the block drops the request and clears both the start bit and the count register. It then emits a one-cycle event toward the interrupt multiplexer. If the mover moved fewer bytes than were asked for, the block records a short transfer in a sticky flag. The next start clears that flag.

The destination offered to the mover is always aligned to 32 bytes and confined to a 29-bit physical space. While a transfer runs, the register file is locked, so the mover sees stable parameters.

Top module: `dma_kick_regs`

## Requirements
- R1: After reset, every register reads 0, and mv_req, done_evt and short_flag are 0.
- R2: While no transfer runs, the destination register (bus_addr 0) and the count register (bus_addr 1) are written by a bus write and read back the full 32-bit value. bus_addr 3 reads 0.
- R3: A bus write to the control register (bus_addr 2) with bit 0 set, made while idle, raises mv_req from the next cycle. Control bit 0 reads 1 until completion.
- R4: While a transfer runs, mv_dest equals the destination register ANDed with 0x1FFFFFE0, and mv_len equals the count register.
- R5: A cycle with mv_done high while a transfer runs ends it. From the next cycle, control bit 0 and the count register read 0 and mv_req is low. The destination register keeps its value.
- R6: done_evt is high for exactly one cycle: the cycle after the completing mv_done.
- R7: Control bit 1 (short_flag) is set at completion when mv_moved is less than the requested count. It stays clear when mv_moved is equal or larger.
- R8: A new start clears the short flag.
- R9: While a transfer runs, bus writes are ignored, including writes in the completing cycle. A start write does not restart the transfer, and destination and count writes do not change those registers.
- R10: mv_done while idle has no effect: there is no event, and the flag and registers are unchanged.
- R11: A control write with bit 0 clear does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 destination, 1 count, 2 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mv_req | output | 1 | Transfer request to the mover, high while busy |
| mv_dest | output | 32 | Aligned destination address |
| mv_len | output | 32 | Requested byte count |
| mv_done | input | 1 | Mover completion strobe |
| mv_moved | input | 32 | Bytes actually moved, valid with mv_done |
| done_evt | output | 1 | One-cycle completion event |
| short_flag | output | 1 | Last transfer moved fewer bytes than requested |

## Verification
Completion and a bus write can land on the same clock edge. That edge is the one where the count is being cleared and the start bit is being dropped. The bench provokes this by holding mv_done together with a count write, and in a second run together with a fresh start write. It then judges that the count reads 0, the channel is idle, and exactly one event fires. A one-pass vector table also covers aligned, unaligned, full-ones and short or long mover reports.

// File: rtl/dkr_pkg.sv
package dkr_pkg;
   typedef enum logic [1:0] {
      SEL_DEST  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_NONE  = 2'd3
   } dkr_sel_e;

   localparam int CTRL_GO_BIT    = 0;
   localparam int CTRL_SHORT_BIT = 1;
endpackage

// File: rtl/dkr_regfile.sv
module dkr_regfile #(
   parameter int DATA_W     = 32,
   parameter int ALIGN_BITS = 5,
   parameter int PHYS_BITS  = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_dest,
   input  logic              wr_count,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   input  logic              clr_count,
   output logic [DATA_W-1:0] dest_q,
   output logic [DATA_W-1:0] count_q,
   output logic [DATA_W-1:0] dest_out
);
   localparam int TOP_BIT = (PHYS_BITS < DATA_W) ? PHYS_BITS : DATA_W;

   generate
      if (ALIGN_BITS >= TOP_BIT) begin : g_bad_align
         $error("dkr_regfile: ALIGN_BITS must be below the physical width");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("dkr_regfile: DATA_W too small");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dest_q  <= '0;
         count_q <= '0;
      end else begin
         if (wr_dest && !busy)
            dest_q <= wdata;
         if (clr_count)
            count_q <= '0;
         else if (wr_count && !busy)
            count_q <= wdata;
      end
   end

   // per-bit alignment and physical window
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         if (i >= ALIGN_BITS && i < TOP_BIT) begin : g_keep
            assign dest_out[i] = dest_q[i];
         end else begin : g_zero
            assign dest_out[i] = 1'b0;
         end
      end
   endgenerate

   // R9: parameters locked while the mover works
   p_dest_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wr_dest |=> $stable(dest_q));
   p_count_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !clr_count |=> $stable(count_q));
endmodule

// File: rtl/dkr_ctrl.sv
module dkr_ctrl #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kick,
   input  logic              mv_done,
   input  logic [DATA_W-1:0] mv_moved,
   input  logic [DATA_W-1:0] req_len,
   output logic              busy,
   output logic              short_q,
   output logic              done_evt,
   output logic              clr_count
);
   logic finish;

   assign finish    = busy && mv_done;
   assign clr_count = finish;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         short_q  <= 1'b0;
         done_evt <= 1'b0;
      end else begin
         done_evt <= finish;
         if (finish) begin
            busy    <= 1'b0;
            short_q <= (mv_moved < req_len);
         end else if (kick && !busy) begin
            busy    <= 1'b1;
            short_q <= 1'b0;
         end
      end
   end

   // R6: event never lasts two cycles
   p_evt_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |=> !done_evt);
   // R3: busy persists until the mover answers
   p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mv_done |=> busy);
   // R7: flag reflects the comparison made at completion
   p_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy && mv_done |=> short_q == ($past(mv_moved) < $past(req_len)));
   // R10: stray completion while idle does nothing
   p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && mv_done && !kick |=> !busy && !done_evt && $stable(short_q));
   // R8: start clears the flag
   p_start_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && kick |=> busy && !short_q);
endmodule

// File: rtl/dkr_rdmux.sv
module dkr_rdmux
   import dkr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  dkr_sel_e          sel,
   input  logic [DATA_W-1:0] dest_q,
   input  logic [DATA_W-1:0] count_q,
   input  logic              busy,
   input  logic              short_q,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      unique case (sel)
         SEL_DEST:  rdata = dest_q;
         SEL_COUNT: rdata = count_q;
         SEL_CTRL: begin
            rdata[CTRL_GO_BIT]    = busy;
            rdata[CTRL_SHORT_BIT] = short_q;
         end
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_kick_regs.sv
module dma_kick_regs
   import dkr_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ALIGN_BITS = 5,
   parameter int PHYS_BITS  = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              mv_req,
   output logic [DATA_W-1:0] mv_dest,
   output logic [DATA_W-1:0] mv_len,
   input  logic              mv_done,
   input  logic [DATA_W-1:0] mv_moved,
   output logic              done_evt,
   output logic              short_flag
);
   dkr_sel_e          sel;
   logic              wr_dest, wr_count, kick;
   logic              busy, short_q, clr_count;
   logic [DATA_W-1:0] dest_q, count_q, dest_out;

   assign sel      = dkr_sel_e'(bus_addr);
   assign wr_dest  = bus_wr && (sel == SEL_DEST);
   assign wr_count = bus_wr && (sel == SEL_COUNT);
   assign kick     = bus_wr && (sel == SEL_CTRL) && bus_wdata[CTRL_GO_BIT];

   dkr_regfile #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS), .PHYS_BITS(PHYS_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_dest(wr_dest), .wr_count(wr_count),
      .wdata(bus_wdata), .busy(busy), .clr_count(clr_count),
      .dest_q(dest_q), .count_q(count_q), .dest_out(dest_out));

   dkr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .kick(kick), .mv_done(mv_done),
      .mv_moved(mv_moved), .req_len(count_q), .busy(busy),
      .short_q(short_q), .done_evt(done_evt), .clr_count(clr_count));

   dkr_rdmux #(.DATA_W(DATA_W)) u_rd (
      .sel(sel), .dest_q(dest_q), .count_q(count_q), .busy(busy),
      .short_q(short_q), .rdata(bus_rdata));

   assign mv_req     = busy;
   assign mv_dest    = dest_out;
   assign mv_len     = count_q;
   assign short_flag = short_q;

   // R5: when the event fires, the channel is already idle with count cleared
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |-> (mv_len == '0) && !mv_req);
   // R4: mover parameters stay put during a transfer
   p_params_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mv_req && $past(mv_req) |-> $stable(mv_dest) && $stable(mv_len));
endmodule

// File: tb/dma_kick_regs_bench.sv
module dma_kick_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mv_req;
   logic [31:0] mv_dest, mv_len;
   logic        mv_done = 1'b0;
   logic [31:0] mv_moved = '0;
   logic        done_evt, short_flag;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   dma_kick_regs u_dma_kick_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mv_req(mv_req),
      .mv_dest(mv_dest), .mv_len(mv_len), .mv_done(mv_done),
      .mv_moved(mv_moved), .done_evt(done_evt), .short_flag(short_flag));

   // dest, count, moved, expected mv_dest, expected short
   localparam logic [128:0] VEC [4] = '{
      {32'h1234_5678, 32'h0000_0100, 32'h0000_0100, 32'h1234_5660, 1'b0},
      {32'hFFFF_FFFF, 32'h0000_0040, 32'h0000_000A, 32'h1FFF_FFE0, 1'b1},
      {32'h0000_001F, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 1'b1},
      {32'hA000_0020, 32'h0000_0020, 32'h0000_0040, 32'h0000_0020, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a; #0.5;
      d = bus_rdata;
   endtask

   task automatic finish_xfer(input logic [31:0] moved);
      mv_done = 1'b1; mv_moved = moved;
      @(posedge clk); #1;
      mv_done = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, r); chk("R1 dest", r, 0);
      rd(2'd1, r); chk("R1 count", r, 0);
      rd(2'd2, r); chk("R1 ctrl", r, 0);
      chk("R1 req/evt/short", {29'd0, mv_req, done_evt, short_flag}, 0);

      // R2 plain read/write while idle
      wr(2'd0, 32'hDEAD_BEEF); rd(2'd0, r); chk("R2 dest rw", r, 32'hDEAD_BEEF);
      wr(2'd1, 32'h0BAD_F00D); rd(2'd1, r); chk("R2 count rw", r, 32'h0BAD_F00D);
      wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, r); chk("R2 unused addr", r, 0);

      // R11 control write with bit0 clear
      wr(2'd2, 32'hFFFF_FFFE);
      chk("R11 no start", {31'd0, mv_req}, 0);

      // R10 stray completion while idle
      finish_xfer(32'h0);
      chk("R10 no event", {31'd0, done_evt}, 0);
      rd(2'd1, r); chk("R10 count kept", r, 32'h0BAD_F00D);

      // table walk: R3 R4 R5 R6 R7 R8
      foreach (VEC[k]) begin
         wr(2'd0, VEC[k][128:97]);
         wr(2'd1, VEC[k][96:65]);
         wr(2'd2, 32'h1);
         chk("R3 req", {31'd0, mv_req}, 1);
         rd(2'd2, r); chk("R3 R8 ctrl busy, short clear", r, 32'h1);
         chk("R4 mv_dest", mv_dest, VEC[k][32:1]);
         chk("R4 mv_len", mv_len, VEC[k][96:65]);
         repeat (2) @(posedge clk); #1;
         chk("R3 still busy", {31'd0, mv_req}, 1);
         finish_xfer(VEC[k][64:33]);
         chk("R6 event", {31'd0, done_evt}, 1);
         chk("R5 req low", {31'd0, mv_req}, 0);
         rd(2'd1, r); chk("R5 count cleared", r, 0);
         rd(2'd0, r); chk("R5 dest kept", r, VEC[k][128:97]);
         chk("R7 short", {31'd0, short_flag}, {31'd0, VEC[k][0]});
         rd(2'd2, r); chk("R7 ctrl", r, {30'd0, VEC[k][0], 1'b0});
         @(posedge clk); #1;
         chk("R6 single pulse", {31'd0, done_evt}, 0);
      end

      // R9 writes while busy ignored
      wr(2'd0, 32'h0000_0100); wr(2'd1, 32'h80); wr(2'd2, 32'h1);
      wr(2'd0, 32'h5555_5555); wr(2'd1, 32'h11); wr(2'd2, 32'h1);
      chk("R9 dest locked", mv_dest, 32'h0000_0100);
      chk("R9 count locked", mv_len, 32'h80);
      // same-cycle completion and count write
      bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h55;
      finish_xfer(32'h80);
      bus_wr = 1'b0;
      rd(2'd1, r); chk("R9 R5 count write at completion", r, 0);
      chk("R6 event at collision", {31'd0, done_evt}, 1);

      // same-cycle completion and start write
      wr(2'd1, 32'h40); wr(2'd2, 32'h1);
      bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h1;
      finish_xfer(32'h40);
      bus_wr = 1'b0;
      chk("R9 no restart at completion", {31'd0, mv_req}, 0);
      @(posedge clk); #1;
      chk("R6 one event only", {31'd0, done_evt}, 0);

      // R8 short flag cleared by the next start
      wr(2'd1, 32'h40); wr(2'd2, 32'h1);
      finish_xfer(32'h3);
      chk("R7 short set", {31'd0, short_flag}, 1);
      wr(2'd1, 32'h40); wr(2'd2, 32'h1);
      chk("R8 cleared on start", {31'd0, short_flag}, 0);
      finish_xfer(32'h40);

      // R1 reset again mid-state
      wr(2'd2, 32'h1);
      rst_n = 1'b0; @(posedge clk); #1; rst_n = 1'b1;
      rd(2'd0, r); chk("R1 dest after reset", r, 0);
      chk("R1 req after reset", {31'd0, mv_req}, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule